// File: doc/BRIEF.md
# SONET B1 Parity and Scrambler Unit

This block handles the section-level parity byte and the frame-synchronous scrambling of an STS-N byte stream, carried one byte per clock. It has two independent directions. The transmit side takes an unscrambled frame. It can overwrite the B1 slot with the parity of the previous frame, and it can scramble the result. The receive side takes a scrambled frame and can descramble it. It also computes parity over the received line bytes and compares that value with the B1 byte of the next frame.

Each direction is framed by a pulse that marks the first byte of a frame. Frame search, serialization and line coding take place outside the block. Parity mismatches appear as a one-cycle flag aligned with the offending byte. They also feed a saturating event counter that clears when it is read. All widths and frame dimensions are parameters. The default frame is STS-12: 9 rows of 90 columns per STS-1.

Top module: `son_b1_scr_unit`

## Requirements
- R1: With tx_scr_en high, each transmitted byte at frame position 3*N or later is XORed with a keystream from the generator 1+x^6+x^7. The generator is reloaded with all ones at position 3*N, and each byte takes 8 generator bits, most significant bit first. The first 3*N bytes of a frame are never scrambled. With tx_scr_en low, no transmitted byte is altered by scrambling.
- R2: With tx_b1_en high, and once a complete frame has been sent since reset, the byte at position COLS*N is replaced by the XOR of every outgoing line byte of the previous frame, taken after scrambling. This replacement happens before scrambling. Otherwise the byte at that position passes through unchanged.
- R3: With rx_dscr_en high, received bytes at position 3*N or later are XORed with the same keystream as in R1. Received bytes before position 3*N are never descrambled. With rx_dscr_en low, every received byte passes through unchanged.
- R4: Receive parity is the XOR of all bytes of a frame as they arrive on the line, before descrambling. At position COLS*N of the next frame, the byte is taken after optional descrambling and compared with that parity. A difference raises rx_b1_err for exactly the cycle in which that byte is presented on rx_data_out. No comparison is made until one complete frame has been received after reset.
- R5: err_count, CNT_W bits wide (16 by default), rises by one on each rx_b1_err pulse. It holds at all ones once it gets there, and it otherwise keeps its value.
- R6: When cnt_rd is high in a cycle, err_count next becomes 1 if a parity error is flagged in that same update and 0 if none is.
- R7: Every byte and frame-start pulse leaves its direction exactly one clock after it enters.
- R8: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fs | input | 1 | Marks the first byte of a transmit frame |
| tx_data_in | input | 8 | Transmit byte, unscrambled |
| tx_scr_en | input | 1 | Enable transmit scrambling |
| tx_b1_en | input | 1 | Enable B1 insertion |
| tx_fs_out | output | 1 | Delayed transmit frame start |
| tx_data_out | output | 8 | Transmit line byte |
| rx_fs | input | 1 | Marks the first byte of a receive frame |
| rx_data_in | input | 8 | Received line byte |
| rx_dscr_en | input | 1 | Enable receive descrambling |
| rx_fs_out | output | 1 | Delayed receive frame start |
| rx_data_out | output | 8 | Received byte, optionally descrambled |
| rx_b1_err | output | 1 | One-cycle parity mismatch flag |
| cnt_rd | input | 1 | Read strobe that clears the error counter |
| err_count | output | CNT_W | Saturating parity error count |

## Verification
A parity mismatch at the B1 slot and a read strobe on the counter can land in the same update. In that case the clear has to keep the new event, not lose it. The bench sets this up by corrupting one line byte of a frame and raising cnt_rd on exactly the B1 byte of the following frame. It then expects err_count to read 1, and it also places strobes away from error slots, where it expects 0. A reduced counter width lets the saturation edge be reached. Every byte of every frame is compared against an arithmetic model under all eight enable combinations.

// File: rtl/son_oh_pkg.sv
package son_oh_pkg;

  localparam int unsigned SCR_W = 7;

  typedef logic [SCR_W-1:0] scr_state_t;

  localparam scr_state_t SCR_SEED = '1;

  // Eight keystream bits from generator 1+x^6+x^7, first bit in the MSB.
  function automatic logic [7:0] scr_key(input scr_state_t s);
    scr_state_t t;
    logic [7:0] k;
    t = s;
    k = '0;
    for (int i = 7; i >= 0; i--) begin
      k[i] = t[6];
      t    = {t[5:0], t[6] ^ t[5]};
    end
    return k;
  endfunction

  // Generator state after eight shifts.
  function automatic scr_state_t scr_step(input scr_state_t s);
    scr_state_t t;
    t = s;
    for (int i = 0; i < 8; i++) begin
      t = {t[5:0], t[6] ^ t[5]};
    end
    return t;
  endfunction

endpackage

// File: rtl/son_frame_pos.sv
module son_frame_pos
  import son_oh_pkg::*;
#(
  parameter int unsigned N    = 12,
  parameter int unsigned ROWS = 9,
  parameter int unsigned COLS = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs,
  output logic [7:0] ks,
  output logic       scr_zone,
  output logic       b1_slot,
  output logic       prev_full
);

  localparam int unsigned FRAME_BYTES = N * ROWS * COLS;
  localparam int unsigned POS_W       = $clog2(FRAME_BYTES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BYTES - 1);
  localparam logic [POS_W-1:0] POS_SCR0 = POS_W'(3 * N);
  localparam logic [POS_W-1:0] POS_B1   = POS_W'(COLS * N);

  logic [POS_W-1:0] pos_q, pos_cur, pos_d;
  scr_state_t       lfsr_q, lfsr_cur, lfsr_d;
  logic             seen_q, seen_d;
  logic             full_q, full_d;

  always_comb begin
    pos_cur   = fs ? '0 : pos_q;
    pos_d     = (pos_cur == POS_LAST) ? '0 : pos_cur + 1'b1;
    scr_zone  = (pos_cur >= POS_SCR0);
    b1_slot   = (pos_cur == POS_B1);
    lfsr_cur  = (pos_cur == POS_SCR0) ? SCR_SEED : lfsr_q;
    ks        = scr_key(lfsr_cur);
    lfsr_d    = scr_step(lfsr_cur);
    seen_d    = seen_q | fs;
    full_d    = full_q | (fs & seen_q);
    prev_full = full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      seen_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      seen_q <= seen_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SCR_SEED;
    end else if (scr_zone) begin
      lfsr_q <= lfsr_d;
    end
  end

endmodule

// File: rtl/son_tx_path.sv
module son_tx_path #(
  parameter int unsigned N    = 12,
  parameter int unsigned ROWS = 9,
  parameter int unsigned COLS = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs,
  input  logic [7:0] data_in,
  input  logic       scr_en,
  input  logic       b1_en,
  output logic       fs_out,
  output logic [7:0] data_out
);

  logic [7:0] ks;
  logic       scr_zone, b1_slot, prev_full;
  logic [7:0] ins_byte, line_byte;
  logic [7:0] acc_q, acc_d, hold_q, hold_d;

  son_frame_pos #(.N(N), .ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs        (fs),
    .ks        (ks),
    .scr_zone  (scr_zone),
    .b1_slot   (b1_slot),
    .prev_full (prev_full)
  );

  always_comb begin
    ins_byte  = (b1_en && b1_slot && prev_full) ? hold_q : data_in;
    line_byte = (scr_en && scr_zone) ? (ins_byte ^ ks) : ins_byte;
    acc_d     = fs ? line_byte : (acc_q ^ line_byte);
    hold_d    = fs ? acc_q : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      hold_q   <= '0;
      fs_out   <= 1'b0;
      data_out <= '0;
    end else begin
      acc_q    <= acc_d;
      hold_q   <= hold_d;
      fs_out   <= fs;
      data_out <= line_byte;
    end
  end

endmodule

// File: rtl/son_rx_path.sv
module son_rx_path #(
  parameter int unsigned N    = 12,
  parameter int unsigned ROWS = 9,
  parameter int unsigned COLS = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs,
  input  logic [7:0] data_in,
  input  logic       dscr_en,
  output logic       fs_out,
  output logic [7:0] data_out,
  output logic       err_out,
  output logic       hit
);

  logic [7:0] ks;
  logic       scr_zone, b1_slot, prev_full;
  logic [7:0] plain_byte;
  logic [7:0] acc_q, acc_d, hold_q, hold_d;

  son_frame_pos #(.N(N), .ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs        (fs),
    .ks        (ks),
    .scr_zone  (scr_zone),
    .b1_slot   (b1_slot),
    .prev_full (prev_full)
  );

  always_comb begin
    plain_byte = (dscr_en && scr_zone) ? (data_in ^ ks) : data_in;
    hit        = b1_slot && prev_full && (plain_byte != hold_q);
    acc_d      = fs ? data_in : (acc_q ^ data_in);
    hold_d     = fs ? acc_q : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      hold_q   <= '0;
      fs_out   <= 1'b0;
      data_out <= '0;
      err_out  <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      hold_q   <= hold_d;
      fs_out   <= fs;
      data_out <= plain_byte;
      err_out  <= hit;
    end
  end

endmodule

// File: rtl/son_err_cnt.sv
module son_err_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             rd,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_d;

  always_comb begin
    if (rd) begin
      count_d = CNT_W'(hit);
    end else if (hit && (count != CNT_MAX)) begin
      count_d = count + 1'b1;
    end else begin
      count_d = count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/son_b1_scr_unit.sv
module son_b1_scr_unit #(
  parameter int unsigned N     = 12,
  parameter int unsigned ROWS  = 9,
  parameter int unsigned COLS  = 90,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_fs,
  input  logic [7:0]       tx_data_in,
  input  logic             tx_scr_en,
  input  logic             tx_b1_en,
  output logic             tx_fs_out,
  output logic [7:0]       tx_data_out,
  input  logic             rx_fs,
  input  logic [7:0]       rx_data_in,
  input  logic             rx_dscr_en,
  output logic             rx_fs_out,
  output logic [7:0]       rx_data_out,
  output logic             rx_b1_err,
  input  logic             cnt_rd,
  output logic [CNT_W-1:0] err_count
);

  logic rx_hit;

  son_tx_path #(.N(N), .ROWS(ROWS), .COLS(COLS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs       (tx_fs),
    .data_in  (tx_data_in),
    .scr_en   (tx_scr_en),
    .b1_en    (tx_b1_en),
    .fs_out   (tx_fs_out),
    .data_out (tx_data_out)
  );

  son_rx_path #(.N(N), .ROWS(ROWS), .COLS(COLS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs       (rx_fs),
    .data_in  (rx_data_in),
    .dscr_en  (rx_dscr_en),
    .fs_out   (rx_fs_out),
    .data_out (rx_data_out),
    .err_out  (rx_b1_err),
    .hit      (rx_hit)
  );

  son_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (rx_hit),
    .rd    (cnt_rd),
    .count (err_count)
  );

endmodule

// File: rtl/son_b1_scr_chk.sv
module son_b1_scr_chk #(
  parameter int unsigned N     = 12,
  parameter int unsigned ROWS  = 9,
  parameter int unsigned COLS  = 90,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_fs,
  input logic [7:0]       tx_data_in,
  input logic             tx_fs_out,
  input logic [7:0]       tx_data_out,
  input logic             rx_fs,
  input logic             rx_fs_out,
  input logic             rx_b1_err,
  input logic             cnt_rd,
  input logic [CNT_W-1:0] err_count
);

  localparam int unsigned FRAME_BYTES = N * ROWS * COLS;
  localparam int unsigned POS_W       = $clog2(FRAME_BYTES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BYTES - 1);
  localparam logic [POS_W-1:0] POS_SCR0 = POS_W'(3 * N);
  localparam logic [POS_W-1:0] POS_B1   = POS_W'(COLS * N);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic             armed_q;
  logic             tx_seen_q, rx_seen_q;
  logic [POS_W-1:0] tx_pos_q, rx_pos_q, tx_cur, rx_cur;

  always_comb begin
    tx_cur = tx_fs_out ? '0 : tx_pos_q;
    rx_cur = rx_fs_out ? '0 : rx_pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      tx_seen_q <= 1'b0;
      rx_seen_q <= 1'b0;
      tx_pos_q  <= '0;
      rx_pos_q  <= '0;
    end else begin
      armed_q   <= 1'b1;
      tx_seen_q <= tx_seen_q | tx_fs_out;
      rx_seen_q <= rx_seen_q | rx_fs_out;
      tx_pos_q  <= (tx_cur == POS_LAST) ? '0 : tx_cur + 1'b1;
      rx_pos_q  <= (rx_cur == POS_LAST) ? '0 : rx_cur + 1'b1;
    end
  end

  assert_tx_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (tx_fs_out == $past(tx_fs)));

  assert_rx_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (rx_fs_out == $past(rx_fs)));

  assert_ovh_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (tx_seen_q || tx_fs_out) && (tx_cur < POS_SCR0))
      |-> (tx_data_out == $past(tx_data_in)));

  assert_err_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_b1_err |-> ((rx_seen_q || rx_fs_out) && (rx_cur == POS_B1)));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_count == CNT_MAX) && !cnt_rd) |=> (err_count == CNT_MAX));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rd |=> (rx_b1_err || $stable(err_count)));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rx_b1_err && !$past(cnt_rd) && ($past(err_count) != CNT_MAX))
      |-> (err_count == $past(err_count) + 1'b1));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd |=> (err_count == CNT_W'(rx_b1_err)));

endmodule

bind son_b1_scr_unit son_b1_scr_chk #(
  .N(N), .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_fs       (tx_fs),
  .tx_data_in  (tx_data_in),
  .tx_fs_out   (tx_fs_out),
  .tx_data_out (tx_data_out),
  .rx_fs       (rx_fs),
  .rx_fs_out   (rx_fs_out),
  .rx_b1_err   (rx_b1_err),
  .cnt_rd      (cnt_rd),
  .err_count   (err_count)
);

// File: tb/son_b1_scr_unit_tb.sv
module son_b1_scr_unit_tb;

  localparam int N     = 1;
  localparam int ROWS  = 9;
  localparam int COLS  = 90;
  localparam int CNT_W = 3;
  localparam int FB    = N * ROWS * COLS;
  localparam int SCR0  = 3 * N;
  localparam int B1P   = COLS * N;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tx_fs, tx_scr_en, tx_b1_en, tx_fs_out;
  logic [7:0]       tx_data_in, tx_data_out;
  logic             rx_fs, rx_dscr_en, rx_fs_out, rx_b1_err;
  logic [7:0]       rx_data_in, rx_data_out;
  logic             cnt_rd;
  logic [CNT_W-1:0] err_count;

  always #5 clk = ~clk;

  son_b1_scr_unit #(.N(N), .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_fs(tx_fs), .tx_data_in(tx_data_in), .tx_scr_en(tx_scr_en), .tx_b1_en(tx_b1_en),
    .tx_fs_out(tx_fs_out), .tx_data_out(tx_data_out),
    .rx_fs(rx_fs), .rx_data_in(rx_data_in), .rx_dscr_en(rx_dscr_en),
    .rx_fs_out(rx_fs_out), .rx_data_out(rx_data_out), .rx_b1_err(rx_b1_err),
    .cnt_rd(cnt_rd), .err_count(err_count)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Configuration applied with the next driven byte
  bit c_scr, c_b1, c_dscr;

  // Arithmetic model state
  int               m_pos;
  bit               m_seen, m_full;
  logic [6:0]       m_lfsr;
  logic [7:0]       m_tacc, m_thold, m_racc, m_rhold;
  logic [CNT_W-1:0] m_cnt;
  logic [7:0]       e_tx, e_rx;
  logic             e_fs, e_err;
  logic [CNT_W-1:0] e_cnt;
  bit               e_valid;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_out();
    chk("R1/R2 tx line byte", 32'(tx_data_out), 32'(e_tx));
    chk("R7 tx frame start", 32'(tx_fs_out), 32'(e_fs));
    chk("R7 rx frame start", 32'(rx_fs_out), 32'(e_fs));
    chk("R3 rx output byte", 32'(rx_data_out), 32'(e_rx));
    chk("R4 parity flag", 32'(rx_b1_err), 32'(e_err));
    chk("R5/R6 error count", 32'(err_count), 32'(e_cnt));
  endtask

  task automatic step(input bit fs, input logic [7:0] d, input bit bad, input bit rd);
    logic [7:0] ks, ins, txo, rxi, plain;
    @(negedge clk);
    if (e_valid) compare_out();
    if (fs) begin
      m_pos  = 0;
      m_full = m_full | m_seen;
      m_seen = 1'b1;
    end
    ks = 8'h00;
    if (m_pos == SCR0) m_lfsr = 7'h7f;
    if (m_pos >= SCR0) begin
      for (int i = 7; i >= 0; i--) begin
        ks[i]  = m_lfsr[6];
        m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      end
    end
    ins   = (c_b1 && m_pos == B1P && m_full) ? m_thold : d;
    txo   = (c_scr && m_pos >= SCR0) ? (ins ^ ks) : ins;
    rxi   = bad ? (txo ^ 8'h01) : txo;
    plain = (c_dscr && m_pos >= SCR0) ? (rxi ^ ks) : rxi;
    e_err = (m_pos == B1P) && m_full && (plain != m_rhold);
    if (fs) begin
      m_thold = m_tacc; m_tacc = txo;
      m_rhold = m_racc; m_racc = rxi;
    end else begin
      m_tacc = m_tacc ^ txo;
      m_racc = m_racc ^ rxi;
    end
    if (rd)                          m_cnt = CNT_W'(e_err);
    else if (e_err && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
    e_cnt   = m_cnt;
    e_tx    = txo;
    e_rx    = plain;
    e_fs    = fs;
    e_valid = 1'b1;
    m_pos   = (m_pos == FB - 1) ? 0 : m_pos + 1;
    tx_fs      = fs;
    tx_data_in = d;
    tx_scr_en  = c_scr;
    tx_b1_en   = c_b1;
    rx_fs      = fs;
    rx_data_in = rxi;
    rx_dscr_en = c_dscr;
    cnt_rd     = rd;
  endtask

  task automatic run_frame(input bit scr, input bit b1, input bit dscr,
                           input int bad_pos, input int rd_pos, input int seed);
    c_scr  = scr;
    c_b1   = b1;
    c_dscr = dscr;
    for (int p = 0; p < FB; p++) begin
      step(p == 0, 8'(p * seed + seed * 7 + (p >> 3)), p == bad_pos, p == rd_pos);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tx_fs = 1'b0; tx_data_in = 8'h00; tx_scr_en = 1'b0; tx_b1_en = 1'b0;
    rx_fs = 1'b0; rx_data_in = 8'h00; rx_dscr_en = 1'b0; cnt_rd = 1'b0;
    m_pos = 0; m_seen = 1'b0; m_full = 1'b0; m_lfsr = 7'h7f;
    m_tacc = 8'h00; m_thold = 8'h00; m_racc = 8'h00; m_rhold = 8'h00;
    m_cnt = '0; e_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R8: everything quiet under reset
    chk("R8 reset tx byte", 32'(tx_data_out), 32'h0);
    chk("R8 reset rx byte", 32'(rx_data_out), 32'h0);
    chk("R8 reset flag", 32'(rx_b1_err), 32'h0);
    chk("R8 reset count", 32'(err_count), 32'h0);
    chk("R8 reset frame starts", 32'({tx_fs_out, rx_fs_out}), 32'h0);
    rst_n = 1'b1;

    // Matched link: clean frames, then corruption, then read coinciding with an error (R6)
    run_frame(1, 1, 1, -1, -1, 3);
    run_frame(1, 1, 1, -1, -1, 5);
    run_frame(1, 1, 1, 400, -1, 7);
    run_frame(1, 1, 1, 400, B1P, 9);
    run_frame(1, 1, 1, -1, 10, 11);
    run_frame(1, 1, 1, -1, 500, 13);

    // Sweep of all enable combinations (R1, R2, R3, R4)
    for (int c = 0; c < 8; c++) begin
      run_frame(c[0], c[1], c[2], -1, 5, 17 + c);
      run_frame(c[0], c[1], c[2], 300 + c, -1, 31 + c);
    end

    // Corrupt the B1 byte itself (R4)
    run_frame(1, 1, 1, -1, 2, 41);
    run_frame(1, 1, 1, B1P, -1, 43);
    run_frame(0, 1, 0, B1P, -1, 47);

    // Saturation with a narrow counter (R5)
    for (int f = 0; f < 10; f++) begin
      run_frame(1, 1, 1, 600, (f == 0) ? 1 : -1, 53 + f);
    end
    run_frame(1, 1, 1, -1, -1, 71);

    @(negedge clk);
    compare_out();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule